// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Fill Flags

This block buffers 36-bit words between a producer on one clock and a consumer on an unrelated clock. Its storage has a power-of-two number of slots. Write and read positions are kept as binary counters, and each domain sends a Gray-coded copy of its counter to the other domain through two flip-flops. Each side works out the fill level from its own counter and the copy it has received from the other side. From that fill level it drives a full or empty indication and an active-low threshold flag, registered on its own clock.

Three values are sampled only while reset is high: the almost-full offset m, the almost-empty offset n, and the read style. In standard style a read strobe moves the next word into the output register on the following read-clock edge. In fall-through style the oldest word is placed in the output register without being asked for. That register then holds one extra word, so the total depth D is the slot count plus one, and the almost-empty threshold moves up by one word.

Top module: `dc_flag_fifo`

## Requirements
- R1: While reset is high and after it falls, with no traffic: empty=1, full=0, af_n=1, ae_n=0.
- R2: Words leave in the same order they were accepted, in both read styles, under any interleaving of the two clocks.
- R3: Standard style (fwft_sel=0 at reset): after an accepted read, rdata presents the next word following the next read-clock edge. full rises once DEPTH words are held.
- R4: Fall-through style (fwft_sel=1 at reset): the oldest word appears on rdata and empty falls without any read strobe. full rises once DEPTH+1 words are held.
- R5: A write attempted while full is dropped. It changes neither the stored words nor the write position.
- R6: A read attempted while empty is dropped. It changes neither rdata nor the read position.
- R7: af_n is low when the settled count is at least D−m and high below that. D is DEPTH in standard style and DEPTH+1 in fall-through style.
- R8: ae_n is low when the settled count is at most n in standard style, or at most n+1 in fall-through style, and high above that.
- R9: m, n and the read style are taken only while reset is high. Changing af_ofs, ae_ofs or fwft_sel afterwards has no effect on the flags or on the behaviour of either port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Master reset, active high, asynchronous to both clocks |
| fwft_sel | input | 1 | Read style sampled during reset: 1 selects fall-through |
| af_ofs | input | AW | Almost-full offset m, sampled during reset |
| ae_ofs | input | AW | Almost-empty offset n, sampled during reset |
| wclk | input | 1 | Write clock |
| wen | input | 1 | Write request |
| wdata | input | DW | Word to store |
| full | output | 1 | No free slot; writes are dropped |
| af_n | output | 1 | Almost-full, active low, write-clock registered |
| rclk | input | 1 | Read clock |
| ren | input | 1 | Read request |
| rdata | output | DW | Output register |
| empty | output | 1 | Nothing to read; reads are dropped |
| ae_n | output | 1 | Almost-empty, active low, read-clock registered |

## Verification
A directed fill adds one word at a time, and a directed drain removes one word at a time. After each step the bench waits for both sides to settle and then checks both flags. This sweep locates each threshold edge exactly and tells the two read styles apart, because their full point and almost-empty edge differ by one word. Extra writes into a full FIFO and extra reads from an empty one show whether blocked requests disturb any position. The offset and style inputs are changed after reset, so a design that keeps tracking them produces wrong flag edges. Random bursts with write-heavy and then read-heavy odds push the clocks through fill and drain crossings, and a reference queue checks word order throughout.

// File: rtl/dc_flag_fifo.sv
module dc_flag_fifo #(
  parameter int DW = 36,
  parameter int AW = 4
) (
  input  logic          rst,
  input  logic          fwft_sel,
  input  logic [AW-1:0] af_ofs,
  input  logic [AW-1:0] ae_ofs,
  input  logic          wclk,
  input  logic          wen,
  input  logic [DW-1:0] wdata,
  output logic          full,
  output logic          af_n,
  input  logic          rclk,
  input  logic          ren,
  output logic [DW-1:0] rdata,
  output logic          empty,
  output logic          ae_n
);
  localparam int DEPTH = 1 << AW;
  localparam int PW = AW + 1;

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DW-1:0] mem [DEPTH];

  // write side
  logic [PW-1:0] wbin, wgray, rg1, rg2;
  logic [AW-1:0] m_q;
  logic [PW-1:0] rsync, wbin_nx, wcnt_nx;
  logic          wr_ok;

  assign rsync   = g2b(rg2);
  assign full    = (wbin - rsync) == PW'(DEPTH);
  assign wr_ok   = wen && !full && !rst;
  assign wbin_nx = wbin + PW'(wr_ok);
  assign wcnt_nx = wbin_nx - rsync;

  always_ff @(posedge wclk or posedge rst)
    if (rst) begin
      wbin  <= '0;
      wgray <= '0;
      rg1   <= '0;
      rg2   <= '0;
      af_n  <= 1'b1;
      m_q   <= af_ofs;
    end else begin
      wbin  <= wbin_nx;
      wgray <= wbin_nx ^ (wbin_nx >> 1);
      rg1   <= rgray;
      rg2   <= rg1;
      af_n  <= wcnt_nx < (PW'(DEPTH) - PW'(m_q));
    end

  always_ff @(posedge wclk)
    if (wr_ok) mem[wbin[AW-1:0]] <= wdata;

  // read side
  logic [PW-1:0] rbin, rgray, wg1, wg2;
  logic [AW-1:0] n_q;
  logic          fw_q, vld;
  logic [PW-1:0] wsync, rbin_nx;
  logic          mem_empty, take, vld_nx;
  logic [PW:0]   tot_nx, ae_lim;

  assign wsync     = g2b(wg2);
  assign mem_empty = wsync == rbin;
  assign take      = fw_q ? (!mem_empty && (!vld || ren)) : (ren && !mem_empty);
  assign vld_nx    = fw_q && (take || (vld && !ren));
  assign rbin_nx   = rbin + PW'(take);
  assign tot_nx    = {1'b0, wsync - rbin_nx} + (PW+1)'(vld_nx);
  assign ae_lim    = (PW+1)'(n_q) + (PW+1)'(fw_q);
  assign empty     = fw_q ? !vld : mem_empty;

  always_ff @(posedge rclk or posedge rst)
    if (rst) begin
      rbin  <= '0;
      rgray <= '0;
      wg1   <= '0;
      wg2   <= '0;
      vld   <= 1'b0;
      ae_n  <= 1'b0;
      rdata <= '0;
      n_q   <= ae_ofs;
      fw_q  <= fwft_sel;
    end else begin
      rbin  <= rbin_nx;
      rgray <= rbin_nx ^ (rbin_nx >> 1);
      wg1   <= wgray;
      wg2   <= wg1;
      vld   <= vld_nx;
      ae_n  <= !(tot_nx <= ae_lim);
      if (take) rdata <= mem[rbin[AW-1:0]];
    end

  // R5
  no_overflow_chk: assert property (@(posedge wclk) disable iff (rst)
    (wen && full) |=> $stable(wbin));
  // R6
  no_underflow_chk: assert property (@(posedge rclk) disable iff (rst)
    (ren && empty && !fw_q) |=> ($stable(rbin) && $stable(rdata)));
  // R7
  full_flags_chk: assert property (@(posedge wclk) disable iff (rst)
    full |-> !af_n);
  // R8
  empty_flags_chk: assert property (@(posedge rclk) disable iff (rst)
    (empty && !fw_q) |-> !ae_n);
endmodule

// File: tb/test_dc_flag_fifo.sv
module test_dc_flag_fifo;
  localparam int DW = 36, AW = 4, DEPTH = 16, M = 3, N = 2;

  logic rst = 1, fwft_sel = 0, wclk = 0, rclk = 0, wen = 0, ren = 0;
  logic [AW-1:0] af_ofs = M, ae_ofs = N;
  logic [DW-1:0] wdata = '0, rdata;
  logic full, af_n, empty, ae_n;

  dc_flag_fifo #(.DW(DW), .AW(AW)) i_dc_flag_fifo (
    .rst(rst), .fwft_sel(fwft_sel), .af_ofs(af_ofs), .ae_ofs(ae_ofs),
    .wclk(wclk), .wen(wen), .wdata(wdata), .full(full), .af_n(af_n),
    .rclk(rclk), .ren(ren), .rdata(rdata), .empty(empty), .ae_n(ae_n));

  always #2.5 wclk = ~wclk;
  always #3.5 rclk = ~rclk;

  int total = 0, bad = 0;
  int fw = 0;
  int wr_todo = 0, rd_todo = 0;
  bit wr_rand = 0, rd_rand = 0, finished = 0;
  int wr_pct = 50, rd_pct = 50;
  logic [DW-1:0] q[$];
  bit pend = 0;
  logic [DW-1:0] pend_exp;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_af_n(int cnt);
    return !(cnt >= DEPTH + fw - M);
  endfunction
  function automatic bit exp_ae_n(int cnt);
    return !(cnt <= N + fw);
  endfunction

  always @(negedge wclk) begin
    if (rst) wen = 0;
    else if (wr_todo > 0 || wr_rand) begin
      wen = wr_rand ? ($urandom_range(99) < wr_pct) : 1'b1;
      wdata = {$urandom, $urandom};
      if (wen && !full) q.push_back(wdata);
      if (!wr_rand) wr_todo--;
    end else wen = 0;
  end

  always @(negedge rclk) begin
    if (rst) begin ren = 0; pend = 0; end
    else begin
      if (pend) begin
        chk(rdata == pend_exp, "R2/R3 order", rdata, pend_exp);
        pend = 0;
      end
      if (fw != 0 && !empty) begin
        if (q.size() == 0) chk(0, "R4 spurious word", rdata, 0);
        else chk(rdata == q[0], "R2/R4 order", rdata, q[0]);
      end
      if (rd_todo > 0 || rd_rand) begin
        ren = rd_rand ? ($urandom_range(99) < rd_pct) : 1'b1;
        if (!rd_rand) rd_todo--;
      end else ren = 0;
      if (ren && !empty && q.size() > 0) begin
        if (fw == 0) begin pend = 1; pend_exp = q[0]; end
        void'(q.pop_front());
      end
    end
  end

  task automatic settle();
    repeat (12) @(negedge rclk);
  endtask
  task automatic do_writes(input int k);
    wr_todo = k;
    wait (wr_todo == 0);
    @(negedge wclk);
    settle();
  endtask
  task automatic do_reads(input int k);
    rd_todo = k;
    wait (rd_todo == 0);
    @(negedge rclk);
    settle();
  endtask

  task automatic flag_chk(input int cnt);
    chk(af_n == exp_af_n(cnt), "R7 af_n", af_n, exp_af_n(cnt));
    chk(ae_n == exp_ae_n(cnt), "R8 ae_n", ae_n, exp_ae_n(cnt));
  endtask

  task automatic run_mode(input int f);
    logic [DW-1:0] hold;
    fw = f;
    rst = 1;
    q.delete();
    fwft_sel = f[0];
    af_ofs = M;
    ae_ofs = N;
    repeat (4) @(negedge rclk);
    chk(empty == 1 && full == 0 && af_n == 1 && ae_n == 0, "R1 in reset",
        {empty, full, af_n, ae_n}, 4'b1010);
    @(negedge wclk);
    rst = 0;
    // R9: late changes must be ignored
    fwft_sel = !f[0];
    af_ofs = 7;
    ae_ofs = 9;
    settle();
    chk(empty == 1 && full == 0 && af_n == 1 && ae_n == 0, "R1 after reset",
        {empty, full, af_n, ae_n}, 4'b1010);
    for (int k = 1; k <= DEPTH + f; k++) begin
      do_writes(1);
      flag_chk(k);
      if (k == 1) chk(empty == 0, f ? "R4 fall-through" : "R3 visible", empty, 0);
      if (k == DEPTH - 1 + f) chk(full == 0, "R3/R4 not yet full", full, 0);
    end
    chk(full == 1, f ? "R4 full at DEPTH+1" : "R3 full at DEPTH", full, 1);
    do_writes(3);
    chk(full == 1, "R5 still full", full, 1);
    flag_chk(DEPTH + f);
    for (int k = DEPTH + f - 1; k >= 0; k--) begin
      do_reads(1);
      flag_chk(k);
    end
    chk(empty == 1, "R6 empty after drain", empty, 1);
    hold = rdata;
    do_reads(3);
    chk(rdata == hold, "R6 rdata kept", rdata, hold);
    chk(empty == 1, "R6 still empty", empty, 1);
    flag_chk(0);
    do_writes(2);
    flag_chk(2);
    do_reads(2);
    chk(empty == 1, "R6 pointers intact", empty, 1);
    // random traffic
    wr_pct = 80; rd_pct = 30;
    wr_rand = 1; rd_rand = 1;
    repeat (1500) @(negedge rclk);
    wr_pct = 25; rd_pct = 85;
    repeat (1500) @(negedge rclk);
    wr_pct = 60; rd_pct = 60;
    repeat (1500) @(negedge rclk);
    wr_rand = 0;
    @(negedge wclk);
    rd_pct = 100;
    repeat (200) @(negedge rclk);
    rd_rand = 0;
    settle();
    chk(q.size() == 0, "R2 all words returned", q.size(), 0);
    chk(empty == 1, "R2 empty at end", empty, 1);
    flag_chk(0);
  endtask

  initial begin
    void'($urandom(1234));
    run_mode(0);
    run_mode(1);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge wclk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule